// File: doc/BRIEF.md
# Oversampling Avionics Serial Word Receiver

This block takes one channel of a bipolar return-to-zero avionics serial line. The line arrives as two digital level signals: one is high while the line carries a ONE level, the other is high while it carries a ZERO level. The block samples the pair ten times per nominal bit. It can run at a fast rate, with one sample per clock, or at a slow rate, with one sample per eight clocks. It times every level phase, every null phase and every bit cell. It also requires a quiet line between words. It drops any word whose pattern or rate is wrong.

A word is accepted when it has exactly 32 bits. The first bit received is stored at bit 0. Bit 31 of the stored word is replaced by the result of an odd-parity check. The accepted word goes into a holding register and an active-low ready flag goes low. A host reads the word over a 16-bit bus in two halves. A half-select input picks the half, and an active-low read enable puts that half on the bus. The ready flag returns high only after both halves have been read, in either order. For two channels, instantiate the block twice.

Top module: `a429_rx_channel`

## Requirements
- R1: With `speed_lo` = 0 the line is sampled on every clock. With `speed_lo` = 1 it is sampled once every 8 clocks. A word sent at the other rate's sample spacing is dropped.
- R2: A valid word is stored with received bit k (k = 1..32) at `word[k-1]`, and `ready_n` goes low.
- R3: Stored bit 31 is 1 when the 32 received bits hold an odd number of ONEs, and 0 otherwise.
- R4: The bit cell, measured from one level start to the next, must last 8 to 12 samples. Otherwise the word is dropped.
- R5: Each level phase must last 3 to 7 samples, and each null between bits of a word 3 to 7 samples. Otherwise the word is dropped.
- R6: A sample with both level inputs high drops the word in progress.
- R7: Only a word of exactly 32 bits is accepted. Words of 31 or 33 bits are dropped.
- R8: A word is accepted only if at least 20 null samples preceded its first level since the last level seen.
- R9: `ready_n` goes low within 16 samples of the start of bit 32.
- R10: While `rd_en_n` is low, `rd_data` shows `word[15:0]` when `rd_sel` = 0 and `word[31:16]` when `rd_sel` = 1. While `rd_en_n` is high, `rd_data` is zero.
- R11: `ready_n` returns high one clock after the read strobe that completes reads of both halves, in either order. A single half read leaves it low.
- R12: A new valid word overwrites an unread word.
- R13: After reset `ready_n` is high and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_lo | input | 1 | 0: sample every clock, 1: sample every 8 clocks |
| line_one | input | 1 | Line is at the ONE level |
| line_zero | input | 1 | Line is at the ZERO level |
| rd_sel | input | 1 | Half select: 0 lower, 1 upper |
| rd_en_n | input | 1 | Active-low read enable / strobe |
| rd_data | output | 16 | Selected half of the held word |
| ready_n | output | 1 | Active-low word-ready flag |

## Verification
The word is registered at the clock edge of the 8th null sample after bit 32, and `ready_n` falls one clock later. This is 14 samples after bit 32 begins when the level lasts 5 samples. The timing check counts samples after bit 32 until the flag falls, and the other word checks sample only after a 25-sample tail. Read data is combinational from the holding register, so it is sampled 1 ns after the enable falls. `ready_n` is updated at the edge that sees the strobe, so it is checked at the following falling edge. A dropped word is confirmed by reading the previous word back unchanged with the flag still high.

// File: rtl/a429_rx_pkg.sv
// Shared types and sizes for the serial word receiver.
package a429_rx_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    // Classified line sample.
    typedef enum logic [1:0] {SYM_NUL, SYM_ONE, SYM_ZER, SYM_BAD} sym_t;

    // Framer state: waiting for a gap, ready for a word, inside a word.
    typedef enum logic [1:0] {FR_WAIT, FR_IDLE, FR_WORD} fr_st_t;
endpackage

// File: rtl/a429_smp_tick.sv
// Sample strobe generator. Emits a one-clock tick every FAST_DIV clocks
// (speed_lo=0) or every SLOW_DIV clocks (speed_lo=1).
// Assumes SLOW_DIV >= FAST_DIV >= 1.
module a429_smp_tick #(
    parameter int FAST_DIV = 1,
    parameter int SLOW_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_lo,
    output logic tick
);
    localparam int CW = $clog2(SLOW_DIV + 1);
    localparam logic [CW-1:0] F_M1 = CW'(FAST_DIV - 1);
    localparam logic [CW-1:0] S_M1 = CW'(SLOW_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Pick the terminal count for the selected rate.
    always_comb lim = speed_lo ? S_M1 : F_M1;

    assign tick = (cnt_q >= lim);

    // Free-running divider, restarting at every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/a429_rx_framer.sv
// Line framer. On each sample tick it classifies the line and measures phase
// and cell lengths in samples. It shifts data bits in, first bit at bit 0.
// It pulses word_vld with the parity-checked word when exactly 32 well-timed
// bits are followed by a null longer than NUL_MAX. A word may start only
// after GAP_MIN null samples. Assumes the inputs are synchronous to clk.
module a429_rx_framer
    import a429_rx_pkg::*;
#(
    parameter int LVL_MIN  = 3,
    parameter int LVL_MAX  = 7,
    parameter int NUL_MIN  = 3,
    parameter int NUL_MAX  = 7,
    parameter int CELL_MIN = 8,
    parameter int CELL_MAX = 12,
    parameter int GAP_MIN  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_one,
    input  logic              line_zero,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_out,
    output logic [5:0]        bits_seen
);
    localparam int RUN_W = $clog2(GAP_MIN + CELL_MAX + 1) + 1;
    localparam logic [RUN_W-1:0] L_MIN  = RUN_W'(LVL_MIN);
    localparam logic [RUN_W-1:0] L_MAX  = RUN_W'(LVL_MAX);
    localparam logic [RUN_W-1:0] N_MIN  = RUN_W'(NUL_MIN);
    localparam logic [RUN_W-1:0] N_END  = RUN_W'(NUL_MAX + 1);
    localparam logic [RUN_W-1:0] C_MIN  = RUN_W'(CELL_MIN);
    localparam logic [RUN_W-1:0] C_MAX  = RUN_W'(CELL_MAX);
    localparam logic [RUN_W-1:0] C_SAT  = RUN_W'(CELL_MAX + 1);
    localparam logic [RUN_W-1:0] G_MIN  = RUN_W'(GAP_MIN);
    localparam logic [RUN_W-1:0] R_SAT  = '1;
    localparam logic [5:0]       N_BITS = 6'(WORD_W);

    sym_t              cur_sym, prv_sym;
    fr_st_t            st_q;
    logic [RUN_W-1:0]  run_q, run_nx, cell_q;
    logic [5:0]        bit_q;
    logic              err_q;
    logic [WORD_W-1:0] shf_q;
    logic              cur_lvl, prv_lvl, lvl_start, lvl_end, lvl_swap;

    // Classify the current line sample.
    always_comb begin
        unique case ({line_one, line_zero})
            2'b00:   cur_sym = SYM_NUL;
            2'b10:   cur_sym = SYM_ONE;
            2'b01:   cur_sym = SYM_ZER;
            default: cur_sym = SYM_BAD;
        endcase
    end

    // Phase edge detection and next run length.
    always_comb begin
        cur_lvl   = (cur_sym == SYM_ONE) || (cur_sym == SYM_ZER);
        prv_lvl   = (prv_sym == SYM_ONE) || (prv_sym == SYM_ZER);
        lvl_start = (prv_sym == SYM_NUL) && cur_lvl;
        lvl_end   = prv_lvl && (cur_sym == SYM_NUL);
        lvl_swap  = prv_lvl && cur_lvl && (cur_sym != prv_sym);
        if (cur_sym != prv_sym)  run_nx = 1;
        else if (run_q == R_SAT) run_nx = run_q;
        else                     run_nx = run_q + 1'b1;
    end

    assign bits_seen = bit_q;

    // Framing state machine, advanced once per sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= FR_WAIT;
            prv_sym  <= SYM_NUL;
            run_q    <= '0;
            cell_q   <= '0;
            bit_q    <= '0;
            err_q    <= 1'b0;
            shf_q    <= '0;
            word_vld <= 1'b0;
            word_out <= '0;
        end else begin
            word_vld <= 1'b0;
            if (tick) begin
                prv_sym <= cur_sym;
                run_q   <= run_nx;
                if (cell_q != C_SAT) cell_q <= cell_q + 1'b1;
                case (st_q)
                    FR_WAIT: begin
                        if (cur_sym == SYM_NUL && run_nx >= G_MIN) st_q <= FR_IDLE;
                    end
                    FR_IDLE: begin
                        if (cur_sym == SYM_BAD) begin
                            st_q <= FR_WAIT;
                        end else if (cur_lvl) begin
                            st_q   <= FR_WORD;
                            bit_q  <= 6'd1;
                            err_q  <= 1'b0;
                            cell_q <= 1;
                            shf_q  <= {cur_sym == SYM_ONE, shf_q[WORD_W-1:1]};
                        end
                    end
                    FR_WORD: begin
                        if (cur_sym == SYM_BAD || lvl_swap) begin
                            st_q <= FR_WAIT;
                        end else if (lvl_start) begin
                            if (run_q < N_MIN || cell_q < C_MIN || cell_q > C_MAX ||
                                bit_q == N_BITS)
                                err_q <= 1'b1;
                            if (bit_q != N_BITS) bit_q <= bit_q + 1'b1;
                            cell_q <= 1;
                            shf_q  <= {cur_sym == SYM_ONE, shf_q[WORD_W-1:1]};
                        end else if (cur_lvl && run_nx > L_MAX) begin
                            st_q <= FR_WAIT;
                        end else if (lvl_end) begin
                            if (run_q < L_MIN) err_q <= 1'b1;
                        end else if (cur_sym == SYM_NUL && run_nx == N_END) begin
                            st_q <= FR_WAIT;
                            if (bit_q == N_BITS && !err_q) begin
                                word_vld <= 1'b1;
                                word_out <= {^shf_q, shf_q[WORD_W-2:0]};
                            end
                        end
                    end
                    default: st_q <= FR_WAIT;
                endcase
            end
        end
    end
endmodule

// File: rtl/a429_rx_hold.sv
// Holding register and two-half readout. Loads the word on word_vld and
// drives ready_n low. Records a read of a half on each falling edge of
// rd_en_n, and releases ready_n once both halves are read. A new word
// always wins over a read in the same cycle.
module a429_rx_hold
    import a429_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rd_sel,
    input  logic              rd_en_n,
    output logic [HALF_W-1:0] rd_data,
    output logic              ready_n
);
    localparam int NHALF = WORD_W / HALF_W;

    logic [WORD_W-1:0] hold_q;
    logic [NHALF-1:0]  done_q, done_nx;
    logic              en_q, strobe;
    logic [HALF_W-1:0] halves [NHALF];

    // Split the held word into bus-wide halves.
    for (genvar g = 0; g < NHALF; g++) begin : g_half
        assign halves[g] = hold_q[g*HALF_W +: HALF_W];
    end

    // Drive the selected half only while the enable is low.
    always_comb rd_data = rd_en_n ? '0 : halves[rd_sel];

    // Read strobe edge and the read set that would follow it.
    always_comb begin
        strobe  = !rd_en_n && en_q;
        done_nx = done_q;
        done_nx[rd_sel] = 1'b1;
    end

    // Holding register, read tracking and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            done_q  <= '0;
            en_q    <= 1'b1;
            ready_n <= 1'b1;
        end else begin
            en_q <= rd_en_n;
            if (word_vld) begin
                hold_q  <= word_in;
                done_q  <= '0;
                ready_n <= 1'b0;
            end else if (strobe && !ready_n) begin
                done_q <= done_nx;
                if (&done_nx) ready_n <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/a429_rx_channel.sv
// One receive channel: sample tick divider, line framer, and the
// holding/readout register. Inputs are assumed synchronous to clk.
module a429_rx_channel
    import a429_rx_pkg::*;
#(
    parameter int FAST_DIV = 1,
    parameter int SLOW_DIV = 8,
    parameter int LVL_MIN  = 3,
    parameter int LVL_MAX  = 7,
    parameter int NUL_MIN  = 3,
    parameter int NUL_MAX  = 7,
    parameter int CELL_MIN = 8,
    parameter int CELL_MAX = 12,
    parameter int GAP_MIN  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        speed_lo,
    input  logic        line_one,
    input  logic        line_zero,
    input  logic        rd_sel,
    input  logic        rd_en_n,
    output logic [15:0] rd_data,
    output logic        ready_n
);
    logic              tick;
    logic              word_vld;
    logic [WORD_W-1:0] word_w;
    logic [5:0]        frm_bits;

    a429_smp_tick #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .speed_lo(speed_lo), .tick(tick)
    );

    a429_rx_framer #(
        .LVL_MIN(LVL_MIN), .LVL_MAX(LVL_MAX), .NUL_MIN(NUL_MIN), .NUL_MAX(NUL_MAX),
        .CELL_MIN(CELL_MIN), .CELL_MAX(CELL_MAX), .GAP_MIN(GAP_MIN)
    ) u_frm (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .line_one(line_one), .line_zero(line_zero),
        .word_vld(word_vld), .word_out(word_w), .bits_seen(frm_bits)
    );

    a429_rx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_w),
        .rd_sel(rd_sel), .rd_en_n(rd_en_n), .rd_data(rd_data), .ready_n(ready_n)
    );
endmodule

// File: rtl/a429_rx_chk.sv
// Protocol checker for the receive channel, bound into every instance.
module a429_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_sel,
    input logic        rd_en_n,
    input logic [15:0] rd_data,
    input logic        ready_n,
    input logic        word_vld,
    input logic [5:0]  frm_bits
);
    // R2
    deliver_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !ready_n);

    // R7
    deliver_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(frm_bits) == 6'd32);

    // R7
    bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_bits <= 6'd32);

    // R11
    release_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_n) |-> $past(!rd_en_n));

    // R11
    ready_holds_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_n && !word_vld) |=> ready_n);

    // R10
    read_data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_n && $past(!rd_en_n) && $stable(rd_sel) && !$past(word_vld))
        |-> $stable(rd_data));
endmodule

bind a429_rx_channel a429_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_en_n(rd_en_n),
    .rd_data(rd_data), .ready_n(ready_n), .word_vld(word_vld), .frm_bits(frm_bits)
);

// File: tb/tb_a429_rx_channel.sv
`timescale 1ns/1ps
module tb_a429_rx_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        speed_lo = 1'b0;
    logic        line_one = 1'b0;
    logic        line_zero = 1'b0;
    logic        rd_sel = 1'b0;
    logic        rd_en_n = 1'b1;
    logic [15:0] rd_data;
    logic        ready_n;

    int n_chk = 0;
    int n_bad = 0;
    int hold_clk = 1;
    logic [31:0] last_exp = '0;
    logic [31:0] seed_dummy;

    always #2.5 clk = ~clk;

    a429_rx_channel dut (
        .clk(clk), .rst_n(rst_n), .speed_lo(speed_lo), .line_one(line_one),
        .line_zero(line_zero), .rd_sel(rd_sel), .rd_en_n(rd_en_n),
        .rd_data(rd_data), .ready_n(ready_n)
    );

    function automatic logic [31:0] exp_word(input logic [31:0] w);
        return {^w, w[30:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic smp(input bit o, input bit z);
        line_one = o;
        line_zero = z;
        repeat (hold_clk) @(negedge clk);
    endtask

    task automatic nulls(input int n);
        for (int i = 0; i < n; i++) smp(1'b0, 1'b0);
    endtask

    // Drive nbits bits (first bit = w[0]); bad_bit >= 0 puts both levels high
    // on that bit's first sample.
    task automatic send(input logic [31:0] w, input int nbits, input int lvl,
                        input int nul, input int tail, input int bad_bit);
        for (int i = 0; i < nbits; i++) begin
            for (int k = 0; k < lvl; k++) begin
                if (i == bad_bit && k == 0) smp(1'b1, 1'b1);
                else smp(w[i % 32], !w[i % 32]);
            end
            if (i < nbits - 1) nulls(nul);
        end
        nulls(tail);
    endtask

    task automatic read_half(input bit sel, output logic [15:0] d);
        rd_sel = sel;
        rd_en_n = 1'b0;
        #1;
        d = rd_data;
        @(negedge clk);
        rd_en_n = 1'b1;
        @(negedge clk);
    endtask

    // Read both halves in the given order and compare with exp.
    task automatic read_word(input logic [31:0] exp, input bit hi_first, input string req);
        logic [15:0] a, b;
        read_half(hi_first, a);
        check(ready_n == 1'b0, "R11 one half read keeps ready low", {31'd0, ready_n}, 32'd0);
        read_half(!hi_first, b);
        if (hi_first) check({a, b} == exp, req, {a, b}, exp);
        else          check({b, a} == exp, req, {b, a}, exp);
        check(ready_n == 1'b1, "R11 ready high after both halves", {31'd0, ready_n}, 32'd1);
    endtask

    // A dropped word: ready stays high and the old word is still held.
    task automatic expect_drop(input string req);
        logic [15:0] d;
        check(ready_n == 1'b1, req, {31'd0, ready_n}, 32'd1);
        read_half(1'b0, d);
        check(d == last_exp[15:0], req, {16'd0, d}, {16'd0, last_exp[15:0]});
    endtask

    task automatic good_word(input logic [31:0] w, input string req);
        send(w, 32, 5, 5, 25, -1);
        check(ready_n == 1'b0, req, {31'd0, ready_n}, 32'd0);
        last_exp = exp_word(w);
        read_word(last_exp, 1'b0, req);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] w;
        logic [15:0] d;
        bit found;
        int k_hit;
        seed_dummy = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        // R13 reset state
        check(ready_n == 1'b1, "R13 ready after reset", {31'd0, ready_n}, 32'd1);
        check(rd_data == 16'd0, "R13 bus idle after reset", {16'd0, rd_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        nulls(25);

        // R2 R3 R10 R11 directed words, odd and even parity
        good_word(32'h0000_0001, "R3 odd count gives bit31=1");
        good_word(32'h8000_0001, "R3 even count gives bit31=0");
        good_word(32'h1234_5678, "R2 R10 lower then upper");
        // R11 upper half first
        w = 32'hA5C3_0F96;
        send(w, 32, 5, 5, 25, -1);
        last_exp = exp_word(w);
        read_word(last_exp, 1'b1, "R11 upper half first");
        // R10 idle bus
        check(rd_data == 16'd0, "R10 bus zero while enable high", {16'd0, rd_data}, 32'd0);

        // R2 constrained random words at the fast rate
        for (int n = 0; n < 30; n++) begin
            w = $urandom;
            send(w, 32, 4 + int'($urandom % 3), 4 + int'($urandom % 3), 25, -1);
            check(ready_n == 1'b0, "R2 random word ready", {31'd0, ready_n}, 32'd0);
            last_exp = exp_word(w);
            read_word(last_exp, bit'($urandom % 2), "R2 random word data");
        end

        // R4 cell too long / too short
        send($urandom, 32, 7, 7, 25, -1);
        expect_drop("R4 cell 14 samples dropped");
        send($urandom, 32, 3, 4, 25, -1);
        expect_drop("R4 cell 7 samples dropped");
        // R5 short level, short null
        send($urandom, 32, 2, 6, 25, -1);
        expect_drop("R5 level 2 samples dropped");
        send($urandom, 32, 6, 2, 25, -1);
        expect_drop("R5 null 2 samples dropped");
        // R6 both levels high
        send($urandom, 32, 5, 5, 25, 17);
        expect_drop("R6 both levels active dropped");
        // R7 wrong bit counts
        send($urandom, 31, 5, 5, 25, -1);
        expect_drop("R7 31 bits dropped");
        send($urandom, 33, 5, 5, 25, -1);
        expect_drop("R7 33 bits dropped");

        // R8 short gap before the next word
        w = $urandom;
        send(w, 32, 5, 5, 10, -1);
        send(~w, 32, 5, 5, 25, -1);
        last_exp = exp_word(w);
        read_word(last_exp, 1'b0, "R8 word after short gap ignored");

        // R12 overwrite of an unread word
        w = $urandom;
        send(w, 32, 5, 5, 25, -1);
        send(w ^ 32'h0F0F_F0F0, 32, 5, 5, 25, -1);
        last_exp = exp_word(w ^ 32'h0F0F_F0F0);
        read_word(last_exp, 1'b0, "R12 newer word kept");

        // R9 ready latency from the start of bit 32
        w = $urandom;
        send(w, 32, 5, 5, 0, -1);
        found = 1'b0;
        k_hit = 0;
        for (int k = 1; k <= 11; k++) begin
            smp(1'b0, 1'b0);
            if (!found && !ready_n) begin
                found = 1'b1;
                k_hit = k;
            end
        end
        check(found, "R9 ready within 16 samples", 32'(5 + k_hit), 32'd16);
        nulls(25);
        last_exp = exp_word(w);
        read_word(last_exp, 1'b0, "R9 latency word data");

        // R1 slow rate
        speed_lo = 1'b1;
        hold_clk = 8;
        nulls(25);
        for (int n = 0; n < 4; n++) begin
            w = $urandom;
            send(w, 32, 4 + int'($urandom % 3), 4 + int'($urandom % 3), 25, -1);
            check(ready_n == 1'b0, "R1 slow word ready", {31'd0, ready_n}, 32'd0);
            last_exp = exp_word(w);
            read_word(last_exp, 1'b0, "R1 slow word data");
        end
        // R1 fast-spaced word while in slow mode
        hold_clk = 1;
        send($urandom, 32, 5, 5, 0, -1);
        hold_clk = 8;
        nulls(25);
        expect_drop("R1 fast spacing dropped in slow mode");
        // R1 slow-spaced word while in fast mode
        speed_lo = 1'b0;
        send($urandom, 32, 5, 5, 25, -1);
        hold_clk = 1;
        nulls(25);
        expect_drop("R1 slow spacing dropped in fast mode");
        read_half(1'b1, d);
        check(d == last_exp[31:16], "R10 upper half after drops", {16'd0, d}, {16'd0, last_exp[31:16]});

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule